// File: doc/BRIEF.md
# Serial Conversion Result Readout Port

This block puts the state of a converter and its held 10-bit result on one serial output pin that can float. Its inputs are an active-low chip select and a serial clock. While chip select is high the pin is released. While chip select is low, the pin is high during a conversion and low once the result is ready. So the pin also works as a busy/ready flag that a host can poll.

When read mode is on and a result is ready, the next falling edge of chip select opens a 16-bit read frame. The frame sends the result most significant bit first and moves on each falling edge of the serial clock. After the ten data bits, the least significant bit is repeated to fill the frame. When the sixteenth falling edge arrives, the block pulses a result-taken strobe back to the sequencer. Chip select and the serial clock are brought into the system clock domain through two-flop synchronizers before any edge is detected.

Top module: `serial_result_port`

## Requirements
- R1: `sdo_oe` is 0 out of reset and in every cycle where chip select, after synchronization, is high.
- R2: With chip select low, no frame open and `conv_busy`=1, the pin is driven (`sdo_oe`=1) with `sdo`=1.
- R3: With chip select low, no frame open, `conv_busy`=0 and `res_ready`=1, the pin is driven with `sdo`=0.
- R4: With chip select low, no frame open and neither busy nor ready, `sdo_oe` is 0.
- R5: A frame opens on a synchronized falling edge of chip select when `rd_mode`=1, `res_ready`=1 and `conv_busy`=0. The first bit driven is `res_data[9]`.
- R6: The frame moves to the next bit only on a synchronized falling edge of `sclk`. Bit k of the frame (k=0..9) is `res_data[9-k]`.
- R7: Frame bits 10 to 15 all equal `res_data[0]`. After 16 bits the pin holds `res_data[0]` until chip select rises.
- R8: `res_taken` is a single-cycle pulse on the sixteenth serial-clock falling edge of a frame, once per frame.
- R9: If chip select rises before sixteen edges, the frame closes and `res_taken` does not pulse.
- R10: With `rd_mode`=0, no frame ever opens. The pin shows only the busy/ready flag and `res_taken` stays 0.
- R11: While `lockout`=1, `sdo_oe` is 0.
- R12: A change on `cs_n` or `sclk` acts two system clocks later, through two synchronizing flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| rd_mode | input | 1 | Read mode enable |
| conv_busy | input | 1 | Sequencer: conversion in progress |
| res_ready | input | 1 | Sequencer: result held and ready |
| res_data | input | 10 | Held conversion result |
| lockout | input | 1 | Sequencer error lockout, forces the pin to float |
| sdo | output | 1 | Serial data / status value |
| sdo_oe | output | 1 | Output enable for `sdo` |
| res_taken | output | 1 | Pulse: a full frame has been shifted out |

## Verification
The assertions assume the following about the inputs. Each `sclk` level lasts at least two system clocks, so every edge reaches the synchronizers. `res_data` does not change while `res_ready` is high. The sequencer never raises `conv_busy` and `res_ready` together. The stimulus holds each serial-clock phase for three system clocks, changes the result only while ready is low, and drops ready only after a taken pulse or between frames. Every input is driven on the falling system-clock edge, half a period away from the sampling edge.

// File: rtl/serial_result_port.sv
module serial_result_port #(
  parameter int DW = 10,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          rd_mode,
  input  logic          conv_busy,
  input  logic          res_ready,
  input  logic [DW-1:0] res_data,
  input  logic          lockout,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          res_taken
);
  localparam int CW = $clog2(FW + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FW - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(FW);
  localparam logic [CW-1:0] CNT_PAD  = CW'(DW);

  logic [1:0]    cs_sync, sck_sync;
  logic          cs_d, sck_d;
  logic          in_frame;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] shreg;

  wire cs_s     = cs_sync[1];
  wire sck_s    = sck_sync[1];
  wire cs_fall  = cs_d & ~cs_s;
  wire sck_fall = sck_d & ~sck_s;
  wire open_req = cs_fall & rd_mode & res_ready & ~conv_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync  <= 2'b11;
      sck_sync <= 2'b00;
      cs_d     <= 1'b1;
      sck_d    <= 1'b0;
    end else begin
      cs_sync  <= {cs_sync[0], cs_n};
      sck_sync <= {sck_sync[0], sclk};
      cs_d     <= cs_s;
      sck_d    <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
    end else if (cs_s) begin
      in_frame <= 1'b0;
      bit_cnt  <= '0;
    end else if (open_req) begin
      in_frame <= 1'b1;
      bit_cnt  <= '0;
      shreg    <= res_data;
    end else if (in_frame && sck_fall && bit_cnt != CNT_FULL) begin
      bit_cnt  <= bit_cnt + 1'b1;
      shreg    <= {shreg[DW-2:0], shreg[0]};
    end
  end

  assign res_taken = in_frame & sck_fall & ~cs_s & (bit_cnt == CNT_LAST);
  assign sdo_oe    = ~cs_s & ~lockout & (in_frame | conv_busy | res_ready);
  assign sdo       = in_frame ? shreg[DW-1] : conv_busy;

  // R12
  cs_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> ##1 !cs_s);
  // R8
  taken_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_taken |=> !res_taken);
  // R7
  pad_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && bit_cnt >= CNT_PAD) |=> (!in_frame || $stable(sdo)));
  // R5
  frame_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> (bit_cnt == '0 && $past(res_ready) && $past(rd_mode)));
  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_FULL);
  // R2
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && conv_busy && sdo_oe) |-> sdo);
endmodule

// File: tb/test_serial_result_port.sv
module test_serial_result_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, rd_mode = 0;
  logic conv_busy = 0, res_ready = 0, lockout = 0;
  logic [9:0] res_data = '0;
  logic sdo, sdo_oe, res_taken;

  int checks = 0, errors = 0, cycles = 0, taken_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_result_port i_serial_result_port (
    .clk, .rst_n, .cs_n, .sclk, .rd_mode, .conv_busy, .res_ready,
    .res_data, .lockout, .sdo, .sdo_oe, .res_taken
  );

  // behavioural model
  bit m_cs[3] = '{1, 1, 1};
  bit m_sk[3] = '{0, 0, 0};
  bit m_frame = 0;
  int m_cnt = 0;
  bit [9:0] m_word = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cs = '{1, 1, 1}; m_sk = '{0, 0, 0}; m_frame = 0; m_cnt = 0;
    end else begin
      if (m_cs[1]) begin
        m_frame = 0; m_cnt = 0;
      end else if (m_cs[2] && rd_mode && res_ready && !conv_busy) begin
        m_frame = 1; m_cnt = 0; m_word = res_data;
      end else if (m_frame && m_sk[2] && !m_sk[1] && m_cnt < 16) begin
        m_cnt++;
      end
      m_cs[2] = m_cs[1]; m_cs[1] = m_cs[0]; m_cs[0] = cs_n;
      m_sk[2] = m_sk[1]; m_sk[1] = m_sk[0]; m_sk[0] = sclk;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_oe, exp_sdo, exp_tk;
      string tag;
      exp_oe  = !m_cs[1] && !lockout && (m_frame || conv_busy || res_ready);
      exp_sdo = m_frame ? m_word[(m_cnt > 9) ? 0 : 9 - m_cnt] : conv_busy;
      exp_tk  = m_frame && !m_cs[1] && m_sk[2] && !m_sk[1] && m_cnt == 15;
      if (m_cs[1]) tag = "R1 R12 cs high oe";
      else if (lockout) tag = "R11 lockout oe";
      else if (m_frame) tag = "R5 frame oe";
      else if (conv_busy) tag = "R2 busy oe";
      else if (res_ready) tag = "R3 ready oe";
      else tag = "R4 idle oe";
      check(tag, sdo_oe, exp_oe);
      if (exp_oe) check(m_frame ? "R6 R7 frame bit" : "R2 R3 flag value", sdo, exp_sdo);
      check("R8 R9 R10 taken", res_taken, exp_tk);
      if (res_taken) taken_cnt++;
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_pulses(int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1; wait_clk(3);
      sclk = 0; wait_clk(3);
    end
  endtask

  task automatic read_frame(logic [9:0] d, int edges, int exp_taken, string tag);
    res_data = d; res_ready = 1; wait_clk(2);
    taken_cnt = 0;
    cs_n = 0; wait_clk(4);
    sck_pulses(edges);
    wait_clk(2);
    checks++;
    if (taken_cnt != exp_taken) begin
      errors++;
      $display("FAIL %s: taken pulses actual %0d expected %0d", tag, taken_cnt, exp_taken);
    end
    cs_n = 1; wait_clk(4);
    if (exp_taken == 1) res_ready = 0;
    wait_clk(2);
  endtask

  initial begin
    wait_clk(3);
    check("R1 reset oe", sdo_oe, 1'b0);
    rst_n = 1; wait_clk(2);
    check("R1 cs high oe", sdo_oe, 1'b0);

    // R12 latency and R2/R4/R3 flag
    conv_busy = 1; wait_clk(1);
    cs_n = 0; wait_clk(1);
    check("R12 one clock after cs low", sdo_oe, 1'b0);
    wait_clk(1);
    check("R12 two clocks after cs low", sdo_oe, 1'b1);
    check("R2 busy high", sdo, 1'b1);
    conv_busy = 0; wait_clk(2);
    check("R4 idle floats", sdo_oe, 1'b0);
    res_ready = 1; res_data = 10'h2B5; wait_clk(2);
    check("R3 ready low", sdo, 1'b0);
    // R11
    lockout = 1; wait_clk(2);
    check("R11 lockout floats", sdo_oe, 1'b0);
    lockout = 0; cs_n = 1; wait_clk(4);
    check("R1 float after cs rise", sdo_oe, 1'b0);

    // R10: read mode off
    rd_mode = 0;
    read_frame(10'h2B5, 16, 0, "R10 no frame");

    // R5..R8 full frames
    rd_mode = 1;
    read_frame(10'h2B5, 16, 1, "R8 full frame");
    read_frame(10'h3FF, 18, 1, "R8 ones frame");
    read_frame(10'h201, 16, 1, "R7 pad frame");
    read_frame(10'h000, 16, 1, "R8 zero frame");

    // R9 abort mid-frame, result still held, then full read
    read_frame(10'h155, 5, 0, "R9 aborted frame");
    read_frame(10'h155, 16, 1, "R9 reread after abort");

    // lockout during frame
    res_data = 10'h0F0; res_ready = 1; wait_clk(2);
    cs_n = 0; wait_clk(4); sck_pulses(3);
    lockout = 1; sck_pulses(2);
    lockout = 0; sck_pulses(11); wait_clk(2);
    cs_n = 1; res_ready = 0; wait_clk(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule